// File: doc/BRIEF.md
# Serial-Chain Memory Bring-Up Sequencer

This block is the controller-side engine that brings a daisy chain of memory devices out of power-up over a slow serial control bus. After a start request it waits a programmable settling pause, then sends a serial reset packet that every device passes down the chain. It follows with a mandatory all-zero write to a guard test register and a broadcast of the channel clock period (in 64 ps units). It ends by giving each device a unique serial identity equal to its position in the chain.

After the reset, every device holds the all-ones identity. The sequencer always addresses that all-ones identity with a directed write. Only the nearest device that is still unassigned responds, takes the next number and then stops matching the all-ones address. The chain length and the clock period value are sampled once, when the start request is accepted. The busy and done outputs report progress. The serial clock and data pins carry fixed-length frames, shifted most significant bit first.

Top module: `chain_init_seq`

## Requirements
- R1: After reset, busy_o, done_o, sck_o and sdo_o are all 0.
- R2: A start accepted while idle raises busy_o on the next cycle. The first rising edge of sck_o comes no sooner than PAUSE_CYCLES serial clock periods (PAUSE_CYCLES*2*SCK_HALF core cycles) after the start.
- R3: The first frame of every sequence is the serial reset packet. Its top eight bits are 8'b00001100 and all remaining bits are zero.
- R4: Each frame is 32 bits and is sent most significant bit first. The fields are: [31:24] command, [23] broadcast flag, [22:18] device address, [17:10] register address, [9:0] data. The data bit is set while sck_o is low and is held steady while sck_o is high, so a receiver samples it on the rising edge.
- R5: The second frame is a broadcast write (command 8'b00000101, broadcast 1, device 0) of data 0 to the guard register at address 8'h4D.
- R6: The third frame is a broadcast write (command 8'b00000101, broadcast 1, device 0) to the period register at address 8'h29. Its data is cycle_time_i as sampled at the start.
- R7: N identity frames follow, for k = 0 to N-1 in that order. Each is a directed write (command 8'b00000101, broadcast 0, device 5'h1F) to register 8'h40 with data k.
- R8: The number of devices N is chain_len_i sampled at the start. A value of 0 counts as 1, and values above 32 count as 32.
- R9: After the last identity frame, busy_o falls and done_o rises. done_o stays high until the next accepted start, which clears it.
- R10: A start while busy_o is high is ignored. Changes of chain_len_i or cycle_time_i while busy do not alter the frames.
- R11: sck_o and sdo_o stay low whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run the bring-up sequence |
| chain_len_i | input | 6 | Number of devices on the chain (1..32) |
| cycle_time_i | input | 10 | Channel clock period in 64 ps units |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, held until next start |
| sck_o | output | 1 | Serial control clock |
| sdo_o | output | 1 | Serial control data, MSB first |

## Verification
The bench decodes the serial stream at the sck_o rising edges and compares each frame with a model built from the requirements. It drives both chain-length extremes and the out-of-range values 0 and 40, alongside random lengths and periods. A mid-run start with changed inputs targets a design that restarts, or that picks up new inputs, partway through; that design would repeat the reset packet or emit the wrong number of identity frames. The timing from start to first clock catches a design that cuts the settling pause short. A hold check on sdo_o during sck_o high catches a shifter that moves its data on the wrong clock phase.

// File: rtl/chain_init_pkg.sv
package chain_init_pkg;
    localparam int CMD_W = 8;
    localparam int REG_W = 8;

    localparam logic [CMD_W-1:0] CMD_SRESET = 8'b0000_1100;
    localparam logic [CMD_W-1:0] CMD_WRITE  = 8'b0000_0101;

    localparam logic [REG_W-1:0] REG_GUARD  = 8'h4D;
    localparam logic [REG_W-1:0] REG_PERIOD = 8'h29;
    localparam logic [REG_W-1:0] REG_SID    = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAUSE,
        ST_SRESET,
        ST_GUARD,
        ST_PERIOD,
        ST_SID
    } seq_state_e;
endpackage

// File: rtl/sck_tick.sv
module sck_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_reg_t;

    tick_reg_t r_d, r_q;

    assign tick_o = en_i && (r_q.cnt == CW'(HALF - 1));

    always_comb begin
        r_d = r_q;
        if (!en_i || tick_o) r_d.cnt = '0;
        else                 r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CW'(HALF - 1));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               sck_o,
    output logic               sdo_o,
    output logic               done_o
);
    localparam int BW = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [BW-1:0]      cnt;
        logic               sck;
        logic               act;
        logic               done;
    } shf_reg_t;

    shf_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (load_i && !r_q.act) begin
            r_d.sh  = frame_i;
            r_d.cnt = BW'(FRAME_W);
            r_d.sck = 1'b0;
            r_d.act = 1'b1;
        end else if (r_q.act && tick_i) begin
            if (!r_q.sck) begin
                r_d.sck = 1'b1;
            end else begin
                r_d.sck = 1'b0;
                r_d.sh  = {r_q.sh[FRAME_W-2:0], 1'b0};
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == BW'(1)) begin
                    r_d.act  = 1'b0;
                    r_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sck_o  = r_q.sck;
    assign sdo_o  = r_q.act & r_q.sh[FRAME_W-1];
    assign done_o = r_q.done;

    // R4
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sck |-> $stable(sdo_o));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.act |-> (!sck_o && !sdo_o));
    // R4
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !r_q.act);
endmodule

// File: rtl/init_fsm.sv
module init_fsm
    import chain_init_pkg::*;
#(
    parameter int DEV_W       = 5,
    parameter int DATA_W      = 10,
    parameter int PAUSE_TICKS = 40,
    parameter int FRAME_W     = CMD_W + 1 + DEV_W + REG_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [DEV_W:0]     len_i,
    input  logic [DATA_W-1:0]  period_i,
    input  logic               tick_i,
    input  logic               sh_done_i,
    output logic               load_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               busy_o,
    output logic               done_o
);
    localparam int PW       = $clog2(PAUSE_TICKS + 1);
    localparam int MAX_DEVS = 1 << DEV_W;

    typedef struct packed {
        seq_state_e        state;
        logic              sent;
        logic [PW-1:0]     pcnt;
        logic [DEV_W-1:0]  idx;
        logic [DEV_W-1:0]  last;
        logic [DATA_W-1:0] period;
        logic              done;
    } fsm_reg_t;

    fsm_reg_t r_d, r_q;
    logic [DEV_W-1:0] last_clamped;

    always_comb begin
        if (len_i == '0)                          last_clamped = '0;
        else if (len_i > (DEV_W+1)'(MAX_DEVS))    last_clamped = '1;
        else                                      last_clamped = DEV_W'(len_i - 1'b1);
    end

    function automatic logic [FRAME_W-1:0] mk_frame(
        input logic [CMD_W-1:0]  cmd,
        input logic              bc,
        input logic [DEV_W-1:0]  dev,
        input logic [REG_W-1:0]  rg,
        input logic [DATA_W-1:0] dat
    );
        return {cmd, bc, dev, rg, dat};
    endfunction

    always_comb begin
        unique case (r_q.state)
            ST_SRESET: frame_o = {CMD_SRESET, {(FRAME_W-CMD_W){1'b0}}};
            ST_GUARD:  frame_o = mk_frame(CMD_WRITE, 1'b1, '0, REG_GUARD, '0);
            ST_PERIOD: frame_o = mk_frame(CMD_WRITE, 1'b1, '0, REG_PERIOD, r_q.period);
            ST_SID:    frame_o = mk_frame(CMD_WRITE, 1'b0, '1, REG_SID, DATA_W'(r_q.idx));
            default:   frame_o = '0;
        endcase
    end

    assign busy_o = (r_q.state != ST_IDLE);
    assign done_o = r_q.done;
    assign load_o = !r_q.sent && (r_q.state == ST_SRESET || r_q.state == ST_GUARD ||
                                  r_q.state == ST_PERIOD || r_q.state == ST_SID);

    always_comb begin
        r_d = r_q;
        if (load_o) r_d.sent = 1'b1;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state  = ST_PAUSE;
                    r_d.done   = 1'b0;
                    r_d.sent   = 1'b0;
                    r_d.pcnt   = '0;
                    r_d.idx    = '0;
                    r_d.last   = last_clamped;
                    r_d.period = period_i;
                end
            end
            ST_PAUSE: begin
                if (r_q.pcnt == PW'(PAUSE_TICKS)) r_d.state = ST_SRESET;
                else if (tick_i)                  r_d.pcnt  = r_q.pcnt + 1'b1;
            end
            default: begin
                if (r_q.sent && sh_done_i) begin
                    r_d.sent = 1'b0;
                    unique case (r_q.state)
                        ST_SRESET: r_d.state = ST_GUARD;
                        ST_GUARD:  r_d.state = ST_PERIOD;
                        ST_PERIOD: r_d.state = ST_SID;
                        default: begin
                            if (r_q.idx == r_q.last) begin
                                r_d.state = ST_IDLE;
                                r_d.done  = 1'b1;
                            end else begin
                                r_d.idx = r_q.idx + 1'b1;
                            end
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    // R8
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.idx <= r_q.last);
    // R2
    pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && r_q.state == ST_SRESET) |-> (r_q.pcnt == PW'(PAUSE_TICKS)));
    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && r_q.state != ST_PAUSE) |=> (r_q.state != ST_PAUSE));
endmodule

// File: rtl/chain_init_seq.sv
module chain_init_seq
    import chain_init_pkg::*;
#(
    parameter int DEV_W        = 5,
    parameter int DATA_W       = 10,
    parameter int SCK_HALF     = 2,
    parameter int PAUSE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DEV_W:0]    chain_len_i,
    input  logic [DATA_W-1:0] cycle_time_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sck_o,
    output logic              sdo_o
);
    localparam int FRAME_W     = CMD_W + 1 + DEV_W + REG_W + DATA_W;
    localparam int PAUSE_TICKS = 2 * PAUSE_CYCLES;

    logic               tick;
    logic               load;
    logic               sh_done;
    logic [FRAME_W-1:0] frame;

    sck_tick #(.HALF(SCK_HALF)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy_o),
        .tick_o (tick)
    );

    init_fsm #(
        .DEV_W       (DEV_W),
        .DATA_W      (DATA_W),
        .PAUSE_TICKS (PAUSE_TICKS),
        .FRAME_W     (FRAME_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .len_i     (chain_len_i),
        .period_i  (cycle_time_i),
        .tick_i    (tick),
        .sh_done_i (sh_done),
        .load_o    (load),
        .frame_o   (frame),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    frame_shifter #(.FRAME_W(FRAME_W)) i_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .load_i  (load),
        .frame_i (frame),
        .sck_o   (sck_o),
        .sdo_o   (sdo_o),
        .done_o  (sh_done)
    );

    // R11
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sck_o && !sdo_o));
endmodule

// File: tb/test_chain_init_seq.sv
module test_chain_init_seq;
    localparam int DEV_W = 5, DATA_W = 10, SCK_HALF = 2, PAUSE_CYCLES = 20;
    localparam int FW = 32;
    localparam int PAUSE_CORE = PAUSE_CYCLES * 2 * SCK_HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DEV_W:0] chain_len = '0;
    logic [DATA_W-1:0] cyc_time = '0;
    logic busy, done, sck, sdo;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    chain_init_seq #(.DEV_W(DEV_W), .DATA_W(DATA_W), .SCK_HALF(SCK_HALF),
                     .PAUSE_CYCLES(PAUSE_CYCLES)) i_chain_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chain_len_i(chain_len),
        .cycle_time_i(cyc_time), .busy_o(busy), .done_o(done), .sck_o(sck), .sdo_o(sdo)
    );

    // serial decoder: samples sdo at each sck rising edge
    logic prev_sck = 1'b0;
    logic prev_sdo = 1'b0;
    logic [FW-1:0] acc = '0;
    int bitn = 0;
    int nframes = 0;
    int hold_err = 0;
    logic [FW-1:0] frames [0:1023];

    always @(negedge clk) begin
        if (sck && prev_sck && (sdo != prev_sdo)) hold_err++;
        if (sck && !prev_sck) begin
            acc = {acc[FW-2:0], sdo};
            bitn++;
            if (bitn == FW) begin
                if (nframes < 1024) frames[nframes] = acc;
                nframes++;
                bitn = 0;
            end
        end
        prev_sck = sck;
        prev_sdo = sdo;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] exp_frame(input int pos, input int n,
                                                input logic [DATA_W-1:0] per);
        if (pos == 0) return {8'b0000_1100, 24'h0};
        if (pos == 1) return {8'b0000_0101, 1'b1, 5'h00, 8'h4D, 10'h000};
        if (pos == 2) return {8'b0000_0101, 1'b1, 5'h00, 8'h29, per};
        return {8'b0000_0101, 1'b0, 5'h1F, 8'h40, 10'(pos - 3)};
    endfunction

    function automatic int clamp_len(input int len);
        if (len == 0) return 1;
        if (len > 32) return 32;
        return len;
    endfunction

    task automatic run_seq(input int len, input logic [DATA_W-1:0] per, input bit poke);
        int base = nframes;
        int n = clamp_len(len);
        int w = 1;
        @(negedge clk);
        start = 1'b1; chain_len = (DEV_W+1)'(len); cyc_time = per;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R9", "busy/done after start", {busy, done}, 2'b10);
        while (!sck && w < 5000) begin @(negedge clk); w++; end
        chk(w >= PAUSE_CORE && w <= PAUSE_CORE + 2*SCK_HALF + 6, "R2",
            "cycles to first sck rise", w, PAUSE_CORE);
        if (poke) begin
            repeat (200) @(negedge clk);
            start = 1'b1;
            chain_len = (DEV_W+1)'($urandom_range(0, 63));
            cyc_time = DATA_W'($urandom);
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        chk(!busy && done, "R9", "busy/done at end", {busy, done}, 2'b01);
        chk(!sck && !sdo, "R11", "pins quiet when idle", {sck, sdo}, 2'b00);
        chk(nframes - base == n + 3, poke ? "R10" : "R8", "frame count", nframes - base, n + 3);
        for (int i = 0; i < n + 3 && base + i < 1024 && base + i < nframes; i++) begin
            string rq;
            rq = (i == 0) ? "R3" : (i == 1) ? "R5" : (i == 2) ? "R6" : "R7";
            chk(frames[base + i] == exp_frame(i, n, per), rq, "frame content",
                frames[base + i], exp_frame(i, n, per));
        end
        repeat (3) @(negedge clk);
        chk(done && !busy, "R9", "done held while idle", {busy, done}, 2'b01);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !sck && !sdo, "R1", "outputs in reset",
            {busy, done, sck, sdo}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !sck && !sdo, "R1", "outputs after reset",
            {busy, done, sck, sdo}, 4'b0000);
        // directed corners
        run_seq(1, 10'h3FF, 1'b0);
        run_seq(32, 10'h001, 1'b0);
        run_seq(0, 10'h155, 1'b0);   // R8 zero length
        run_seq(40, 10'h2AA, 1'b0);  // R8 above maximum
        run_seq(63, 10'h0F0, 1'b1);  // R10 poke while busy
        run_seq(5, 10'h123, 1'b1);   // R10
        // random
        for (int k = 0; k < 6; k++)
            run_seq($urandom_range(1, 32), DATA_W'($urandom), bit'($urandom_range(0, 1)));
        chk(hold_err == 0, "R4", "sdo moved while sck high", hold_err, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule